// File: doc/BRIEF.md
# Up-Counting Overflow Event Timer

This block is a 32-bit event timer that counts upward by one on each cycle in which its tick enable is high, and flags an overflow when the count steps past all-ones. Software expresses a delay as a complement. To get the flag after N further ticks past all-ones minus N, it places that value in the reload register and starts the timer with the load-now bit set. The timer then runs either once (one-shot) or repeatedly (periodic, reloading on each overflow). With a reload value of zero in periodic mode it free-runs over the full range, and its count can be read at any time.

Software reaches the block through a simple word-wide register port: a write strobe with address and data, and a combinational read path. Control writes (run, periodic, load-now) pass through a fixed resynchronisation delay before they act on the counter. Reload, interrupt-enable and status writes act at once. A single interrupt line is high while the overflow status flag and its enable are both set.

Top module: `upcount_evt_timer`

## Requirements
- R1: After reset the count, reload value, run bit, periodic bit, interrupt enable and overflow status all read 0, and irq is low.
- R2: While running, each clock edge with tick high adds one to the count; with tick low the count holds.
- R3: A tick while the count is all-ones sets the overflow status (address 4, bit 0), readable from the next cycle. A count started at 0xFFFFFFFF-N therefore flags on the (N+1)th tick.
- R4: In one-shot mode (periodic bit clear), the overflow clears the run bit and leaves the count at 0; further ticks do not change it.
- R5: In periodic mode (control bit 1 set), the overflow loads the count from the reload register (address 1), giving an event every period.
- R6: A control write (address 0) takes effect on the second clock edge after the edge that accepts it. Until then the control register reads its old value.
- R7: A control write with load-now (bit 2) set copies the reload register into the count when the write takes effect. Control bit 0 is run; load-now reads back as 0.
- R8: A reload register write is visible on the next read and does not change the count until an overflow or a load-now.
- R9: A control write with run clear stops the count; ticks after it takes effect leave the count and status unchanged.
- R10: Writing 1 to status bit 0 clears the overflow flag; writing 0 leaves it set.
- R11: A status clear written on the same edge as a new overflow leaves the flag set.
- R12: irq is high exactly when the overflow status and the interrupt enable (address 3, bit 0) are both set.
- R13: With reload 0 and periodic mode, the count wraps from all-ones to 0 and keeps counting, and the running count stays readable at address 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one increment per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 control, 1 reload, 3 irq enable, 4 status) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address (adds 2 for the live count) |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Overflow interrupt |

## Verification
The bench reads the control register in each cycle after a write and so pins the two-edge latency. A design with one stage too few or too many shows the new run bit a cycle early or late. It steps the count one tick at a time up to all-ones and checks that the flag appears on the wrapping tick and not on the tick that reaches all-ones, which catches an off-by-one compare. It drives a status clear and a wrapping tick on the same edge, where a design that gives the clear priority drops the event. It also checks that one-shot stops at 0 and that a zero reload gives an unbroken free run.

// File: rtl/uct_pkg.sv
package uct_pkg;

    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 3'd0,
        RA_RELOAD = 3'd1,
        RA_COUNT  = 3'd2,
        RA_IEN    = 3'd3,
        RA_STATUS = 3'd4
    } reg_addr_e;

    localparam int unsigned CTRL_RUN_BIT = 0;
    localparam int unsigned CTRL_PER_BIT = 1;
    localparam int unsigned CTRL_LDN_BIT = 2;

    typedef struct packed {
        logic load_now;
        logic periodic;
        logic run;
    } ctrl_cmd_t;

    typedef struct packed {
        logic      valid;
        ctrl_cmd_t cmd;
    } ctrl_req_t;

    function automatic ctrl_cmd_t decode_ctrl(input logic [2:0] bits);
        ctrl_cmd_t c;
        c.run      = bits[CTRL_RUN_BIT];
        c.periodic = bits[CTRL_PER_BIT];
        c.load_now = bits[CTRL_LDN_BIT];
        return c;
    endfunction

endpackage

// File: rtl/uct_resync.sv
module uct_resync
    import uct_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  ctrl_req_t req_i,
    output ctrl_req_t req_o
);

    ctrl_req_t pipe_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) pipe_q[0] <= '0;
                else     pipe_q[0] <= req_i;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) pipe_q[s] <= '0;
                else     pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign req_o = pipe_q[STAGES-1];

endmodule

// File: rtl/uct_counter.sv
module uct_counter
    import uct_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  ctrl_req_t    apply,
    input  logic [W-1:0] reload,
    output logic [W-1:0] count,
    output logic         running,
    output logic         periodic,
    output logic         ovf_evt
);

    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;
    logic         run_q;
    logic         per_q;
    logic         at_top;

    assign at_top  = (cnt_q == ALL_ONES);
    assign ovf_evt = run_q && tick && at_top;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            per_q <= 1'b0;
        end else begin
            if (run_q && tick) begin
                if (at_top) begin
                    cnt_q <= per_q ? reload : '0;
                    if (!per_q) run_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + ONE;
                end
            end
            if (apply.valid) begin
                run_q <= apply.cmd.run;
                per_q <= apply.cmd.periodic;
                if (apply.cmd.load_now) cnt_q <= reload;
            end
        end
    end

    assign count    = cnt_q;
    assign running  = run_q;
    assign periodic = per_q;

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!(run_q && tick) && !apply.valid) |=> $stable(cnt_q));

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (run_q && tick && !at_top && !apply.valid) |=> (cnt_q == $past(cnt_q) + ONE));

    assert_oneshot_stop_R4: assert property (@(posedge clk) disable iff (rst)
        (ovf_evt && !per_q && !apply.valid) |=> (!run_q && cnt_q == '0));

    assert_periodic_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (ovf_evt && per_q && !apply.valid) |=> (cnt_q == $past(reload)));

endmodule

// File: rtl/uct_regfile.sv
module uct_regfile
    import uct_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              ovf_evt,
    output ctrl_req_t         ctrl_req,
    output logic [W-1:0]      reload,
    output logic              ien,
    output logic              status,
    output logic              irq
);

    logic [W-1:0] reload_q;
    logic         ien_q;
    logic         status_q;
    logic         clr_hit;

    assign clr_hit = wr_en && (wr_addr == RA_STATUS) && wr_data[0];

    assign ctrl_req.valid = wr_en && (wr_addr == RA_CTRL);
    assign ctrl_req.cmd   = decode_ctrl(wr_data[2:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            ien_q    <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == RA_RELOAD) reload_q <= wr_data;
            if (wr_addr == RA_IEN)    ien_q    <= wr_data[0];
        end
    end

    // A new event outranks a clear on the same edge.
    always_ff @(posedge clk) begin
        if (rst)          status_q <= 1'b0;
        else if (ovf_evt) status_q <= 1'b1;
        else if (clr_hit) status_q <= 1'b0;
    end

    assign reload = reload_q;
    assign ien    = ien_q;
    assign status = status_q;
    assign irq    = status_q & ien_q;

    assert_flag_on_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> status_q);

    assert_w1c_R10: assert property (@(posedge clk) disable iff (rst)
        (clr_hit && !ovf_evt) |=> !status_q);

    assert_no_spurious_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (!ovf_evt && !status_q) |=> !status_q);

endmodule

// File: rtl/upcount_evt_timer.sv
module upcount_evt_timer
    import uct_pkg::*;
#(
    parameter int unsigned W           = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    output logic              irq
);

    ctrl_req_t    ctrl_req;
    ctrl_req_t    ctrl_apply;
    logic [W-1:0] reload;
    logic [W-1:0] count;
    logic         running;
    logic         periodic;
    logic         ovf_evt;
    logic         ien;
    logic         status;

    uct_regfile #(.W(W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ovf_evt  (ovf_evt),
        .ctrl_req (ctrl_req),
        .reload   (reload),
        .ien      (ien),
        .status   (status),
        .irq      (irq)
    );

    uct_resync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .req_i (ctrl_req),
        .req_o (ctrl_apply)
    );

    uct_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .apply    (ctrl_apply),
        .reload   (reload),
        .count    (count),
        .running  (running),
        .periodic (periodic),
        .ovf_evt  (ovf_evt)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_CTRL: begin
                rd_data[CTRL_RUN_BIT] = running;
                rd_data[CTRL_PER_BIT] = periodic;
            end
            RA_RELOAD: rd_data    = reload;
            RA_COUNT:  rd_data    = count;
            RA_IEN:    rd_data[0] = ien;
            RA_STATUS: rd_data[0] = status;
            default:   rd_data    = '0;
        endcase
    end

    assert_stop_freezes_R9: assert property (@(posedge clk) disable iff (rst)
        (!running && !ctrl_apply.valid) |=> $stable(count));

endmodule

// File: tb/upcount_evt_timer_bench.sv
`timescale 1ns/10ps
module upcount_evt_timer_bench;

    localparam int IRQ_KIND = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    always #4 clk = ~clk;

    upcount_evt_timer u_upcount_evt_timer (
        .clk(clk), .rst(rst), .tick(tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb [$];
    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Monitor: pops expected items and compares against the ports.
    initial begin
        forever begin
            sb_item_t it;
            logic [31:0] act;
            wait (sb.size() != 0);
            #0.1;
            it  = sb.pop_front();
            act = (it.kind == IRQ_KIND) ? {31'b0, irq} : rd_data;
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic chk(input int kind, input logic [31:0] exp, input string tag);
        sb_item_t it;
        if (kind != IRQ_KIND) rd_addr = kind[2:0];
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb.push_back(it);
        #0.2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(0, 32'h0, "R1 ctrl after reset");
        chk(1, 32'h0, "R1 reload after reset");
        chk(2, 32'h0, "R1 count after reset");
        chk(3, 32'h0, "R1 ien after reset");
        chk(4, 32'h0, "R1 status after reset");
        chk(IRQ_KIND, 32'h0, "R1 irq after reset");

        wr(1, 32'hFFFF_FFFA);
        chk(1, 32'hFFFF_FFFA, "R8 reload readback");
        chk(2, 32'h0, "R8 count untouched by reload write");
        wr(0, 32'h5);
        chk(0, 32'h0, "R6 ctrl one cycle after write");
        @(negedge clk);
        chk(0, 32'h0, "R6 ctrl two cycles after write");
        @(negedge clk);
        chk(0, 32'h1, "R6 ctrl applied");
        chk(2, 32'hFFFF_FFFA, "R7 load-now copied reload");

        ticks(3);
        chk(2, 32'hFFFF_FFFD, "R2 three ticks");
        repeat (2) @(negedge clk);
        chk(2, 32'hFFFF_FFFD, "R2 hold with tick low");

        ticks(2);
        chk(2, 32'hFFFF_FFFF, "R3 count at all-ones");
        chk(4, 32'h0, "R3 no flag before wrap");
        ticks(1);
        chk(4, 32'h1, "R3 flag on wrapping tick");
        chk(2, 32'h0, "R4 one-shot count at zero");
        chk(0, 32'h0, "R4 one-shot run cleared");
        ticks(2);
        chk(2, 32'h0, "R4 no counting after one-shot");

        chk(IRQ_KIND, 32'h0, "R12 irq masked");
        wr(3, 32'h1);
        chk(IRQ_KIND, 32'h1, "R12 irq enabled with flag");
        wr(4, 32'h0);
        chk(4, 32'h1, "R10 write zero keeps flag");
        wr(4, 32'h1);
        chk(4, 32'h0, "R10 write one clears flag");
        chk(IRQ_KIND, 32'h0, "R12 irq low after clear");

        wr(1, 32'hFFFF_FFFD);
        wr(0, 32'h7);
        repeat (2) @(negedge clk);
        chk(0, 32'h3, "R5 periodic running");
        chk(2, 32'hFFFF_FFFD, "R7 load-now periodic");
        ticks(3);
        chk(4, 32'h1, "R5 first period flag");
        chk(2, 32'hFFFF_FFFD, "R5 reloaded");
        wr(4, 32'h1);
        ticks(3);
        chk(4, 32'h1, "R5 second period flag");
        chk(2, 32'hFFFF_FFFD, "R5 reloaded again");
        wr(4, 32'h1);

        ticks(2);
        chk(2, 32'hFFFF_FFFF, "R11 at all-ones");
        tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'h1;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        chk(4, 32'h1, "R11 clear loses to new overflow");
        chk(2, 32'hFFFF_FFFD, "R5 reload at same-edge wrap");

        wr(4, 32'h1);
        wr(0, 32'h0);
        repeat (2) @(negedge clk);
        chk(0, 32'h0, "R9 stopped");
        ticks(4);
        chk(2, 32'hFFFF_FFFD, "R9 count frozen");
        chk(4, 32'h0, "R9 no flag while stopped");

        wr(1, 32'hFFFF_FFFE);
        wr(0, 32'h7);
        repeat (2) @(negedge clk);
        wr(1, 32'h0);
        chk(2, 32'hFFFF_FFFE, "R8 reload write leaves count");
        ticks(2);
        chk(2, 32'h0, "R13 wrap to zero");
        chk(4, 32'h1, "R13 flag on free-run wrap");
        ticks(3);
        chk(2, 32'h3, "R13 free-run continues");
        chk(0, 32'h3, "R13 still running");

        repeat (2) @(negedge clk);
        wait (sb.size() == 0);
        #1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule